// File: doc/BRIEF.md
# Network Control Register Sequencer

This block holds the control word of a token-passing network node and carries out the side effects of its bits. The host writes the word over a plain 8-bit bus and reads it back. The word holds five fields: an online-enable bit, a receive-stop bit, a broadcast-accept bit, a transmit-mode bit and a single/continuous send bit. The block drives each field as a level to the network core.

Three bits do more than store a value. When online-enable rises, the block fires a soft-reset pulse of fixed length, and that pulse clears itself. A receive-stop write is only a request. The node applies it when its own token returns, which the core reports with a one-cycle strobe. When the applied receive-stop value falls from 1 to 0, the block sets every flag in a bank of receive-ready flags back to 1. After each applied change, a settle counter runs for a number of time-base ticks set by the data rate. A busy status covers both the wait for the token and the settle time.

Top module: `netctl_seq`

## Requirements
- R1: Reset values. online is the value of standalone_mode. Every other control bit, the applied receive-stop value, busy and soft_rst are 0. Every receive-ready flag is 1.
- R2: Control word layout. Bit 0 is online-enable, bit 1 is receive-stop (the requested value), bit 2 is broadcast-accept, bit 3 is remote-buffer transmit mode and bit 4 is single-packet send. A write with host_we updates the word at the next clock edge. host_rdata returns the word in bits 4:0, busy in bit 7, and 0 in bits 6:5.
- R3: A write that takes online-enable from 0 to 1 raises soft_rst in the cycle after the write. soft_rst then stays high for exactly RST_LEN cycles and falls with no host action.
- R4: Writing online-enable as 0, or as 1 while it is already 1, starts no pulse. A 0-to-1 write made while a pulse is running reloads the pulse to a full RST_LEN cycles.
- R5: The applied receive-stop value changes only at a clock edge where own_token is high. At that edge it takes the requested value. fbe_nak equals the applied value, and rx_cmd_en is its inverse.
- R6: At an edge where the applied receive-stop value goes from 1 to 0, all receive-ready flags become 1. This reload overrides any rx_flag_clr bit in the same cycle. A 0-to-1 change reloads nothing.
- R7: Apart from a reload, each rx_flag_clr bit clears its own flag at the next edge. The other flags are not affected.
- R8: A token edge that changes the applied value loads the settle counter. The load is 2*BASE_TICKS when rate_sel is 0, BASE_TICKS when rate_sel is 1, and BASE_TICKS/2 when rate_sel is 2 or 3. After the load, the counter drops by one at each edge where tick is high.
- R9: busy is high whenever the requested and applied receive-stop values differ, or the settle counter is nonzero. Otherwise it is low.
- R10: When a write and own_token fall in the same cycle, the token applies the request that was held before that write, and the new request stays pending.
- R11: bcast_accept, tx_remote and one_shot show bits 2, 3 and 4 of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standalone_mode | input | 1 | 1 sets the online reset value to 1 |
| host_we | input | 1 | Write strobe for the control word |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Control word and busy bit |
| own_token | input | 1 | Strobe: the node's own token has returned |
| tick | input | 1 | Time-base tick for the settle counter |
| rate_sel | input | 2 | Data rate: 0 slow, 1 nominal, 2 or 3 fast |
| rx_flag_clr | input | NFLAG | Per-flag clear requests |
| rx_ready | output | NFLAG | Receive-ready flag bank |
| online | output | 1 | Online-enable level |
| soft_rst | output | 1 | Self-clearing soft-reset pulse |
| fbe_nak | output | 1 | Answer NAK to free-buffer enquiries |
| rx_cmd_en | output | 1 | Automatic receive commands allowed |
| bcast_accept | output | 1 | Accept broadcast packets |
| tx_remote | output | 1 | Remote-buffer transmit mode |
| one_shot | output | 1 | Send a single packet rather than continuously |
| busy | output | 1 | Receive-stop change pending or settling |

## Verification
Two collisions can happen on the same edge.

- **Flag reload against flag clear.** A token that applies receive-stop 1-to-0 can arrive while the core asks to clear receive-ready flags. The bench drives own_token together with all rx_flag_clr bits high and expects every flag to read 1 on the next cycle.
- **Host write against token.** A host write of receive-stop can coincide with the token strobe. The bench writes a new request on the token cycle. It expects the applied value to take the previous request, with busy still high and the new request read back, until a later token applies it.

// File: rtl/netctl_pkg.sv
`timescale 1ns/1ps
package netctl_pkg;

    typedef enum logic [1:0] {
        RATE_SLOW  = 2'd0,
        RATE_NOM   = 2'd1,
        RATE_FAST  = 2'd2,
        RATE_FAST2 = 2'd3
    } rate_e;

    // Packed so that online sits at bit 0 and one_shot at bit 4.
    typedef struct packed {
        logic one_shot;
        logic tx_remote;
        logic bcast;
        logic rx_stop;
        logic online;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic int unsigned settle_ticks(input logic [1:0] rate, input int unsigned base);
        case (rate_e'(rate))
            RATE_SLOW: return base * 2;
            RATE_NOM:  return base;
            default:   return base / 2;
        endcase
    endfunction

endpackage

// File: rtl/netctl_softrst.sv
`timescale 1ns/1ps
module netctl_softrst #(
    parameter int RST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic pulse
);
    localparam int CW = $clog2(RST_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm)
            st_d.cnt = CW'(RST_LEN);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = (st_q.cnt != '0);

    p_arm_raises_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> pulse);
    p_pulse_counts_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
    p_restart_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (st_q.cnt == CW'(RST_LEN)));

endmodule

// File: rtl/netctl_rxstop.sv
`timescale 1ns/1ps
module netctl_rxstop #(
    parameter int BASE_TICKS = 52
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       own_token,
    input  logic       tick,
    input  logic [1:0] rate_sel,
    output logic       applied,
    output logic       reload,
    output logic       busy
);
    import netctl_pkg::*;

    localparam int CW = $clog2(2 * BASE_TICKS + 1);

    typedef struct packed {
        logic          eff;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic change;

    always_comb begin
        st_d   = st_q;
        change = own_token && (req != st_q.eff);
        if (change) begin
            st_d.eff = req;
            st_d.cnt = CW'(settle_ticks(rate_sel, BASE_TICKS));
        end else if (tick && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign applied = st_q.eff;
    assign reload  = change && st_q.eff && !req;
    assign busy    = (req != st_q.eff) || (st_q.cnt != '0);

    p_apply_on_token_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !own_token |=> $stable(applied));
    p_pending_is_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req != applied) |-> busy);
    p_settle_holds_without_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !own_token) |=> $stable(st_q.cnt));

endmodule

// File: rtl/netctl_flagbank.sv
`timescale 1ns/1ps
module netctl_flagbank #(
    parameter int NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [NFLAG-1:0] clr,
    output logic [NFLAG-1:0] flags
);
    typedef struct packed {
        logic [NFLAG-1:0] f;
    } st_t;

    st_t st_d, st_q;
    logic [NFLAG-1:0] nxt;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_comb begin
            if (reload)      nxt[g] = 1'b1;
            else if (clr[g]) nxt[g] = 1'b0;
            else             nxt[g] = st_q.f[g];
        end
    end

    always_comb begin
        st_d   = st_q;
        st_d.f = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{f: '1};
        else        st_q <= st_d;
    end

    assign flags = st_q.f;

    p_reload_sets_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (&flags));
    p_clear_lowers_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && clr != '0) |=> ((flags & $past(clr)) == '0));

endmodule

// File: rtl/netctl_seq.sv
`timescale 1ns/1ps
module netctl_seq #(
    parameter int NFLAG      = 4,
    parameter int RST_LEN    = 4,
    parameter int BASE_TICKS = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standalone_mode,
    input  logic             host_we,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic             own_token,
    input  logic             tick,
    input  logic [1:0]       rate_sel,
    input  logic [NFLAG-1:0] rx_flag_clr,
    output logic [NFLAG-1:0] rx_ready,
    output logic             online,
    output logic             soft_rst,
    output logic             fbe_nak,
    output logic             rx_cmd_en,
    output logic             bcast_accept,
    output logic             tx_remote,
    output logic             one_shot,
    output logic             busy
);
    import netctl_pkg::*;

    localparam int PAD_W = 8 - 1 - CTL_W;

    typedef struct packed {
        ctl_t ctl;
    } st_t;

    st_t  st_d, st_q;
    ctl_t wr_ctl;
    logic arm;
    logic applied;
    logic reload;

    always_comb begin
        st_d   = st_q;
        wr_ctl = ctl_t'(host_wdata[CTL_W-1:0]);
        arm    = host_we && wr_ctl.online && !st_q.ctl.online;
        if (host_we)
            st_d.ctl = wr_ctl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.ctl.online <= standalone_mode;
        end else begin
            st_q <= st_d;
        end
    end

    netctl_softrst #(.RST_LEN(RST_LEN)) i_softrst (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .pulse (soft_rst)
    );

    netctl_rxstop #(.BASE_TICKS(BASE_TICKS)) i_rxstop (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (st_q.ctl.rx_stop),
        .own_token (own_token),
        .tick      (tick),
        .rate_sel  (rate_sel),
        .applied   (applied),
        .reload    (reload),
        .busy      (busy)
    );

    netctl_flagbank #(.NFLAG(NFLAG)) i_flagbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload),
        .clr    (rx_flag_clr),
        .flags  (rx_ready)
    );

    assign host_rdata   = {busy, {PAD_W{1'b0}}, st_q.ctl};
    assign online       = st_q.ctl.online;
    assign fbe_nak      = applied;
    assign rx_cmd_en    = !applied;
    assign bcast_accept = st_q.ctl.bcast;
    assign tx_remote    = st_q.ctl.tx_remote;
    assign one_shot     = st_q.ctl.one_shot;

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |=> (host_rdata[CTL_W-1:0] == $past(host_wdata[CTL_W-1:0])));
    p_no_pulse_on_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !host_wdata[0] && !soft_rst) |=> !soft_rst);
    p_nak_matches_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fbe_nak != rx_cmd_en);

endmodule

// File: tb/test_netctl_seq.sv
`timescale 1ns/1ps
module test_netctl_seq;

    localparam int NFLAG = 4;
    localparam int RST_LEN = 4;
    localparam int BASE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standalone_mode = 1'b0;
    logic host_we = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic own_token = 1'b0;
    logic tick = 1'b1;
    logic [1:0] rate_sel = 2'd1;
    logic [NFLAG-1:0] rx_flag_clr = '0;
    logic [NFLAG-1:0] rx_ready;
    logic online, soft_rst, fbe_nak, rx_cmd_en, bcast_accept, tx_remote, one_shot, busy;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    netctl_seq #(.NFLAG(NFLAG), .RST_LEN(RST_LEN), .BASE_TICKS(BASE)) i_netctl_seq (
        .clk(clk), .rst_n(rst_n), .standalone_mode(standalone_mode),
        .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .own_token(own_token), .tick(tick), .rate_sel(rate_sel),
        .rx_flag_clr(rx_flag_clr), .rx_ready(rx_ready), .online(online),
        .soft_rst(soft_rst), .fbe_nak(fbe_nak), .rx_cmd_en(rx_cmd_en),
        .bcast_accept(bcast_accept), .tx_remote(tx_remote), .one_shot(one_shot),
        .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] v);
        host_we = 1'b1;
        host_wdata = v;
        step();
        host_we = 1'b0;
    endtask

    task automatic token();
        own_token = 1'b1;
        step();
        own_token = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && busy; i++) step();
    endtask

    task automatic do_reset(input logic sa);
        standalone_mode = sa;
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    function automatic int exp_wait(input int r);
        if (r == 0) return 2 * BASE;
        if (r == 1) return BASE;
        return BASE / 2;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int n;
        // R1 reset values, both modes
        do_reset(1'b0);
        chk("R1 rdata peripheral", host_rdata, 8'h00);
        chk("R1 flags", rx_ready, 4'hF);
        chk("R1 soft_rst", soft_rst, 0);
        chk("R1 busy", busy, 0);
        do_reset(1'b1);
        chk("R1 rdata standalone", host_rdata, 8'h01);
        chk("R1 no pulse from reset online", soft_rst, 0);

        // R3 pulse length from offline
        do_reset(1'b0);
        wr(8'h01);
        n = 0;
        while (soft_rst && n < 20) begin n++; step(); end
        chk("R3 pulse length", n, RST_LEN);
        // R4 no pulse on 1->1 or 1->0
        wr(8'h01);
        chk("R4 rewrite online no pulse", soft_rst, 0);
        wr(8'h00);
        chk("R4 drop online no pulse", soft_rst, 0);
        // R4 restart during pulse
        wr(8'h01);
        step();
        wr(8'h00);
        chk("R4 pulse continues after drop", soft_rst, 1);
        wr(8'h01);
        n = 0;
        while (soft_rst && n < 20) begin n++; step(); end
        chk("R4 restart full length", n, RST_LEN);

        // R2 R11 sweep of the plain control bits
        for (int v = 0; v < 8; v++) begin
            wr(8'(1 | (v << 2)));
            chk("R2 readback", host_rdata, 8'(1 | (v << 2)));
            chk("R11 bcast", bcast_accept, v & 1);
            chk("R11 tx_remote", tx_remote, (v >> 1) & 1);
            chk("R11 one_shot", one_shot, (v >> 2) & 1);
        end
        wr(8'hE1);
        chk("R2 bits 6:5 read 0", host_rdata, 8'h01);

        // R5 R8 R9 deferred receive-stop at each rate
        for (int r = 0; r < 4; r++) begin
            rate_sel = 2'(r);
            wr(8'h03);
            chk("R9 busy on pending", busy, 1);
            chk("R2 busy in rdata", host_rdata, 8'h83);
            step(); step(); step();
            chk("R5 no apply before token", fbe_nak, 0);
            chk("R5 rx_cmd_en before token", rx_cmd_en, 1);
            token();
            chk("R5 applied at token", fbe_nak, 1);
            chk("R5 rx_cmd_en after token", rx_cmd_en, 0);
            n = 0;
            while (busy && n < 40) begin n++; step(); end
            chk("R8 settle ticks", n, exp_wait(r));
            wr(8'h01);
            token();
            drain();
        end

        // R8 counter holds without tick
        rate_sel = 2'd1;
        wr(8'h03);
        token();
        tick = 1'b0;
        step(); step(); step(); step(); step(); step();
        chk("R8 hold without tick", busy, 1);
        tick = 1'b1;
        drain();
        chk("R9 busy clears", busy, 0);

        // R9 token with nothing pending, rewrite same value
        token();
        chk("R9 idle token no busy", busy, 0);
        wr(8'h03);
        chk("R9 same value no busy", busy, 0);
        wr(8'h01);
        token();
        drain();

        // R7 R6 flag clear and reload
        rx_flag_clr = 4'b0101;
        step();
        rx_flag_clr = '0;
        chk("R7 individual clear", rx_ready, 4'b1010);
        wr(8'h03);
        token();
        chk("R6 no reload on stop", rx_ready, 4'b1010);
        drain();
        wr(8'h01);
        chk("R6 no reload before token", rx_ready, 4'b1010);
        own_token = 1'b1;
        rx_flag_clr = 4'b1111;
        step();
        own_token = 1'b0;
        rx_flag_clr = '0;
        chk("R6 reload beats clear", rx_ready, 4'b1111);
        drain();

        // R10 write and token in the same cycle
        wr(8'h03);
        host_we = 1'b1;
        host_wdata = 8'h01;
        own_token = 1'b1;
        step();
        host_we = 1'b0;
        own_token = 1'b0;
        chk("R10 token applies prior request", fbe_nak, 1);
        chk("R10 new request read back", host_rdata[1], 0);
        chk("R10 still busy", busy, 1);
        rx_flag_clr = 4'b0011;
        step();
        rx_flag_clr = '0;
        token();
        chk("R10 later token applies new", fbe_nak, 0);
        chk("R6 reload after R10", rx_ready, 4'b1111);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule